// File: doc/BRIEF.md
# Ternary Flow Matcher with Action Lookup

This block classifies a header key against a small table of ternary rules. Each rule stores, for every key bit, a two-bit code that accepts a 0, accepts a 1, accepts either value, or accepts nothing. All rules are compared with the key in the same cycle, which gives one match line per rule. A priority encoder picks the lowest-numbered matching rule, and that index reads a separate action memory. The result is a hit flag, the winning index and its action word. A key that no rule accepts is flagged so that the surrounding logic can send the packet to the controller.

A controller-side write port loads rule codes and action words one entry at a time. Lookups are pipelined over two registers and accept a new key every cycle. The first stage registers the match lines. The second stage runs the priority encoder and the action read, and registers the result. A two-state stage controller tracks whether the second stage holds a live lookup. Its states are `ST_IDLE` (no key was captured on the last edge) and `ST_RESOLVE` (a key was captured and its result is formed this cycle). It moves to `ST_RESOLVE` on any cycle with `key_valid` high and to `ST_IDLE` on any cycle with `key_valid` low, whatever its current state.

Top module: `tcam_flow_matcher`

## Requirements
- R1: Key bit i is compared with rule code bits [2i+1:2i]. Code 2'b01 accepts only a key bit of 0, code 2'b10 accepts only 1, and code 2'b11 accepts either value. A rule matches when every one of its bits accepts.
- R2: A rule that holds code 2'b00 in any bit position never matches, whatever its other codes are.
- R3: Every rule is compared on each lookup. Keys presented on consecutive cycles each produce their own result on consecutive cycles.
- R4: When several rules match, the rule with the lowest index wins.
- R5: On a hit, `res_idx` carries the winning rule's index and `res_action` carries the action word stored at that index.
- R6: On a miss, `res_valid`=1, `res_hit`=0, `res_miss`=1, `res_idx`=0 and `res_action`=0.
- R7: A key sampled at a rising edge with `key_valid`=1 gives `res_valid`=1 after the second rising edge from then, for exactly one cycle per key. `res_valid`, `res_hit` and `res_miss` are 0 in every other cycle.
- R8: A rule write is seen by lookups whose key is presented in a later cycle. A lookup presented in the same cycle as the write sees the old rule.
- R9: An action write is seen by lookups whose key is presented in a later cycle.
- R10: After reset, all outputs are 0, every rule holds code 2'b00 in every bit, and every action word is 0. Until rules are written, every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | Key on `key` is to be looked up |
| key | input | KEY_W | Header key |
| rule_we | input | 1 | Write `rule_codes` into entry `rule_idx` |
| rule_idx | input | IDX_W | Rule entry to write |
| rule_codes | input | 2*KEY_W | Two-bit code per key bit, bit i at [2i+1:2i] |
| act_we | input | 1 | Write `act_data` into action slot `act_idx` |
| act_idx | input | IDX_W | Action slot to write |
| act_data | input | ACT_W | Action word |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | At least one rule matched |
| res_miss | output | 1 | No rule matched; forward to controller |
| res_idx | output | IDX_W | Winning rule index (0 on miss) |
| res_action | output | ACT_W | Action word of the winning rule (0 on miss) |

## Verification
A corrupted code in rule storage shows at the ports as a wrong hit, a wrong miss or a different winning index, two edges after the first key that the corrupted bit decides. A stage controller stuck in one state shows at once as a missing or extra `res_valid` pulse. A faulty priority encoder shows on keys that several rules accept, so the vectors put overlapping rules in deliberate index order. A stale action slot shows as a wrong `res_action` for an index that is otherwise correct.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    typedef enum logic [1:0] {
        TC_NEVER = 2'b00,
        TC_ZERO  = 2'b01,
        TC_ONE   = 2'b10,
        TC_ANY   = 2'b11
    } tcode_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_RESOLVE = 1'b1
    } stage_e;

    // upper code bit accepts a 1, lower code bit accepts a 0
    function automatic logic code_accepts(input logic [1:0] code, input logic kbit);
        return (code[1] & kbit) | (code[0] & ~kbit);
    endfunction

    function automatic logic code_is_never(input logic [1:0] code);
        return code == TC_NEVER;
    endfunction

endpackage

// File: rtl/tcam_rule_store.sv
module tcam_rule_store #(
    parameter int KEY_W   = 8,
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CODE_W = 2 * KEY_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [IDX_W-1:0]                widx,
    input  logic [CODE_W-1:0]               wcodes,
    output logic [ENTRIES-1:0][CODE_W-1:0]  codes
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                codes[e] <= '0;
            end else if (we && widx == IDX_W'(e)) begin
                codes[e] <= wcodes;
            end
        end
    end

    // R8
    rule_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> codes[$past(widx)] == $past(wcodes));

endmodule

// File: rtl/tcam_match_array.sv
module tcam_match_array #(
    parameter int KEY_W   = 8,
    parameter int ENTRIES = 8,
    localparam int CODE_W = 2 * KEY_W
) (
    input  logic [KEY_W-1:0]                key,
    input  logic [ENTRIES-1:0][CODE_W-1:0]  codes,
    output logic [ENTRIES-1:0]              match
);
    import tcam_pkg::*;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_row
        logic [KEY_W-1:0] bit_ok;
        for (genvar b = 0; b < KEY_W; b++) begin : g_bit
            assign bit_ok[b] = code_accepts(codes[e][2*b +: 2], key[b]);
        end
        assign match[e] = &bit_ok;
    end

endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] req,
    output logic               hit,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
        hit = |req;
    end

endmodule

// File: rtl/tcam_action_ram.sv
module tcam_action_ram #(
    parameter int ENTRIES = 8,
    parameter int ACT_W   = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   widx,
    input  logic [ACT_W-1:0]   wdata,
    input  logic [IDX_W-1:0]   ridx,
    output logic [ACT_W-1:0]   rdata
);

    logic [ENTRIES-1:0][ACT_W-1:0] slots;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots[e] <= '0;
            end else if (we && widx == IDX_W'(e)) begin
                slots[e] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (ridx == IDX_W'(i)) begin
                rdata = slots[i];
            end
        end
    end

    // R9
    act_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> slots[$past(widx)] == $past(wdata));

endmodule

// File: rtl/tcam_flow_matcher.sv
module tcam_flow_matcher #(
    parameter int KEY_W   = 8,
    parameter int ENTRIES = 8,
    parameter int ACT_W   = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CODE_W = 2 * KEY_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               key_valid,
    input  logic [KEY_W-1:0]   key,
    input  logic               rule_we,
    input  logic [IDX_W-1:0]   rule_idx,
    input  logic [CODE_W-1:0]  rule_codes,
    input  logic               act_we,
    input  logic [IDX_W-1:0]   act_idx,
    input  logic [ACT_W-1:0]   act_data,
    output logic               res_valid,
    output logic               res_hit,
    output logic               res_miss,
    output logic [IDX_W-1:0]   res_idx,
    output logic [ACT_W-1:0]   res_action
);
    import tcam_pkg::*;

    logic [ENTRIES-1:0][CODE_W-1:0] codes;
    logic [ENTRIES-1:0]             match_now;
    logic [ENTRIES-1:0]             match_q;
    logic                           enc_hit;
    logic [IDX_W-1:0]               enc_idx;
    logic [ACT_W-1:0]               act_rd;
    stage_e                         stage_q;
    stage_e                         stage_d;

    tcam_rule_store #(.KEY_W(KEY_W), .ENTRIES(ENTRIES)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (rule_we),
        .widx   (rule_idx),
        .wcodes (rule_codes),
        .codes  (codes)
    );

    tcam_match_array #(.KEY_W(KEY_W), .ENTRIES(ENTRIES)) u_match (
        .key   (key),
        .codes (codes),
        .match (match_now)
    );

    // stage 1: capture match lines against the rules as they stand this cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
        end else begin
            match_q <= key_valid ? match_now : '0;
        end
    end

    tcam_prio_enc #(.ENTRIES(ENTRIES)) u_prio (
        .req (match_q),
        .hit (enc_hit),
        .idx (enc_idx)
    );

    tcam_action_ram #(.ENTRIES(ENTRIES), .ACT_W(ACT_W)) u_act (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (act_we),
        .widx  (act_idx),
        .wdata (act_data),
        .ridx  (enc_idx),
        .rdata (act_rd)
    );

    // stage controller: next state
    always_comb begin
        unique case (stage_q)
            ST_IDLE:    stage_d = key_valid ? ST_RESOLVE : ST_IDLE;
            ST_RESOLVE: stage_d = key_valid ? ST_RESOLVE : ST_IDLE;
            default:    stage_d = ST_IDLE;
        endcase
    end

    // stage controller: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= ST_IDLE;
        end else begin
            stage_q <= stage_d;
        end
    end

    // stage controller: registered result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_hit    <= 1'b0;
            res_miss   <= 1'b0;
            res_idx    <= '0;
            res_action <= '0;
        end else begin
            unique case (stage_q)
                ST_IDLE: begin
                    res_valid  <= 1'b0;
                    res_hit    <= 1'b0;
                    res_miss   <= 1'b0;
                    res_idx    <= '0;
                    res_action <= '0;
                end
                ST_RESOLVE: begin
                    res_valid  <= 1'b1;
                    res_hit    <= enc_hit;
                    res_miss   <= ~enc_hit;
                    res_idx    <= enc_hit ? enc_idx : '0;
                    res_action <= enc_hit ? act_rd : '0;
                end
                default: begin
                    res_valid  <= 1'b0;
                    res_hit    <= 1'b0;
                    res_miss   <= 1'b0;
                    res_idx    <= '0;
                    res_action <= '0;
                end
            endcase
        end
    end

    // ---------------- assertions ----------------
    logic [ENTRIES-1:0] below_winner;
    logic [ENTRIES-1:0] has_never;

    always_comb begin
        below_winner = (ENTRIES'(1) << enc_idx) - ENTRIES'(1);
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
        always_comb begin
            has_never[e] = 1'b0;
            for (int b = 0; b < KEY_W; b++) begin
                if (code_is_never(codes[e][2*b +: 2])) begin
                    has_never[e] = 1'b1;
                end
            end
        end
        // R2
        never_code_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            has_never[e] |-> !match_now[e]);
    end

    // R7
    resolve_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == ST_RESOLVE) |=> res_valid);

    // R7
    idle_gives_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == ST_IDLE) |=> !res_valid && !res_hit && !res_miss);

    // R6
    miss_outputs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss |-> res_valid && !res_hit && res_idx == '0 && res_action == '0);

    // R4
    lowest_index_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == ST_RESOLVE && enc_hit) |-> match_q[enc_idx] && ((match_q & below_winner) == '0));

endmodule

// File: tb/tcam_flow_matcher_tb.sv
`timescale 1ns/1ps
module tcam_flow_matcher_tb;

    localparam int KEY_W   = 8;
    localparam int ENTRIES = 8;
    localparam int ACT_W   = 16;
    localparam int IDX_W   = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               key_valid = 1'b0;
    logic [KEY_W-1:0]   key = '0;
    logic               rule_we = 1'b0;
    logic [IDX_W-1:0]   rule_idx = '0;
    logic [2*KEY_W-1:0] rule_codes = '0;
    logic               act_we = 1'b0;
    logic [IDX_W-1:0]   act_idx = '0;
    logic [ACT_W-1:0]   act_data = '0;
    logic               res_valid, res_hit, res_miss;
    logic [IDX_W-1:0]   res_idx;
    logic [ACT_W-1:0]   res_action;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tcam_flow_matcher #(.KEY_W(KEY_W), .ENTRIES(ENTRIES), .ACT_W(ACT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key(key),
        .rule_we(rule_we), .rule_idx(rule_idx), .rule_codes(rule_codes),
        .act_we(act_we), .act_idx(act_idx), .act_data(act_data),
        .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
        .res_idx(res_idx), .res_action(res_action)
    );

    typedef struct packed {
        logic [7:0]  k;
        logic        hit;
        logic [2:0]  idx;
        logic [15:0] act;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{8'hAC, 1'b1, 3'd0, 16'h1111},   // R4: rules 0 and 1 both accept
        '{8'hA3, 1'b1, 3'd0, 16'h1111},   // R1: prefix 1010xxxx
        '{8'h01, 1'b1, 3'd2, 16'h3333},   // R4: rules 2 and 3 both accept
        '{8'h05, 1'b1, 3'd3, 16'h4444},   // R1
        '{8'h7F, 1'b1, 3'd3, 16'h4444},   // R1
        '{8'hC1, 1'b1, 3'd5, 16'h6666},   // R1
        '{8'hFD, 1'b1, 3'd5, 16'h6666},   // R1
        '{8'hC2, 1'b0, 3'd0, 16'h0000},   // R2: rule 4 would accept but holds a 00 code
        '{8'hFF, 1'b0, 3'd0, 16'h0000},   // R6
        '{8'h80, 1'b0, 3'd0, 16'h0000}    // R6
    };

    function automatic logic [2*KEY_W-1:0] mk_codes(input logic [KEY_W-1:0] val,
                                                     input logic [KEY_W-1:0] care);
        logic [2*KEY_W-1:0] c;
        for (int i = 0; i < KEY_W; i++) begin
            c[2*i +: 2] = care[i] ? (val[i] ? 2'b10 : 2'b01) : 2'b11;
        end
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expect_v);
        checks++;
        if (actual !== expect_v) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expect_v);
        end
    endtask

    task automatic wr_rule(input int idx, input logic [2*KEY_W-1:0] c);
        @(negedge clk);
        rule_we = 1'b1; rule_idx = IDX_W'(idx); rule_codes = c;
        @(negedge clk);
        rule_we = 1'b0;
    endtask

    task automatic wr_act(input int idx, input logic [ACT_W-1:0] d);
        @(negedge clk);
        act_we = 1'b1; act_idx = IDX_W'(idx); act_data = d;
        @(negedge clk);
        act_we = 1'b0;
    endtask

    task automatic check_result(input string req, input logic hit,
                                input logic [2:0] idx, input logic [15:0] act);
        chk(req, {31'd0, res_valid}, 32'd1);
        chk(req, {30'd0, res_hit, res_miss}, {30'd0, hit, ~hit});
        chk(req, {29'd0, res_idx}, {29'd0, idx});
        chk(req, {16'd0, res_action}, {16'd0, act});
    endtask

    task automatic lookup(input string req, input logic [7:0] k, input logic hit,
                          input logic [2:0] idx, input logic [15:0] act);
        @(negedge clk);
        key_valid = 1'b1; key = k;
        @(negedge clk);
        key_valid = 1'b0;
        @(negedge clk);
        check_result(req, hit, idx, act);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: outputs during and right after reset
        chk("R10 valid in reset", {31'd0, res_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 outputs after reset", {res_valid, res_hit, res_miss, res_idx, res_action}, 32'd0);
        // R10: empty table misses every key
        lookup("R10 empty table", 8'hAC, 1'b0, 3'd0, 16'h0);
        lookup("R10 empty table", 8'h00, 1'b0, 3'd0, 16'h0);

        wr_rule(0, mk_codes(8'hA0, 8'hF0));
        wr_rule(1, mk_codes(8'hAC, 8'hFF));
        wr_rule(2, mk_codes(8'h01, 8'hFF));
        wr_rule(3, mk_codes(8'h00, 8'h80));
        wr_rule(4, 16'hFFFF & ~(16'h0003 << 6));
        wr_rule(5, mk_codes(8'hC1, 8'hC3));
        wr_act(0, 16'h1111); wr_act(1, 16'h2222); wr_act(2, 16'h3333);
        wr_act(3, 16'h4444); wr_act(4, 16'h5555); wr_act(5, 16'h6666);
        wr_act(7, 16'h7777);

        for (int v = 0; v < NVEC; v++) begin
            lookup("R1 R2 R4 R5 R6 vector", VECS[v].k, VECS[v].hit, VECS[v].idx, VECS[v].act);
        end

        // R7: exact timing of the valid pulse
        @(negedge clk);
        key_valid = 1'b1; key = 8'h05;
        @(negedge clk);
        key_valid = 1'b0;
        chk("R7 no valid after one edge", {31'd0, res_valid}, 32'd0);
        @(negedge clk);
        check_result("R7 valid after two edges", 1'b1, 3'd3, 16'h4444);
        @(negedge clk);
        chk("R7 single cycle pulse", {29'd0, res_valid, res_hit, res_miss}, 32'd0);

        // R3: back-to-back keys
        @(negedge clk);
        key_valid = 1'b1; key = 8'h01;
        @(negedge clk);
        key = 8'hC1;
        @(negedge clk);
        key = 8'hFF;
        check_result("R3 first of burst", 1'b1, 3'd2, 16'h3333);
        @(negedge clk);
        key_valid = 1'b0;
        check_result("R3 second of burst", 1'b1, 3'd5, 16'h6666);
        @(negedge clk);
        check_result("R3 third of burst", 1'b0, 3'd0, 16'h0000);

        // R8: rule write in the same cycle as a lookup is not seen by it
        @(negedge clk);
        rule_we = 1'b1; rule_idx = 3'd7; rule_codes = 16'hFFFF;
        key_valid = 1'b1; key = 8'h80;
        @(negedge clk);
        rule_we = 1'b0; key_valid = 1'b0;
        @(negedge clk);
        check_result("R8 same-cycle write unseen", 1'b0, 3'd0, 16'h0000);
        lookup("R8 later lookup sees catch-all", 8'h80, 1'b1, 3'd7, 16'h7777);

        // R9: rewritten action reaches later lookups
        wr_act(0, 16'hABCD);
        lookup("R9 new action word", 8'hA3, 1'b1, 3'd0, 16'hABCD);

        // R2 R8: invalidating rule 0 lets lower-priority rules win
        wr_rule(0, 16'h0000);
        lookup("R2 invalidated rule skipped", 8'hA3, 1'b1, 3'd7, 16'h7777);
        lookup("R4 next rule wins", 8'hAC, 1'b1, 3'd1, 16'h2222);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule